// File: doc/BRIEF.md
# Address Phase Wait-State Sequencer

This block times the address tenure on a shared processor bus. When a transfer start is seen, it works out how many wait states the address phase needs, counts them down and then acknowledges the address phase for one clock. On that same clock it samples the snoop retry input. The sample tells the bus whether the tenure was retried or may go on to a data tenure.

The wait count depends on who started the transfer. For a processor, the count is the largest of three values: the programmed address-phase minimum, the L2 hit delay when an L2 cache is fitted, and the snoop wait count in a multiprocessor system. A processor clocked at the same rate as the bus forces at least one wait state. For a transfer started by the bridge, the count is the snoop wait field, plus one when the bus pipeline reports that it is busy.

The block handles one tenure at a time. All inputs are plain control pins sampled on the rising clock edge. There is no streaming data path, so there is no valid/ready handshake.

Top module: `addr_wait_ctrl`

## Requirements
- R1: After reset, `aack_o`, `retry_o`, `data_req_o`, `retried_o` and `busy_o` are all 0.
- R2: `ts_i` is accepted on a rising edge where `busy_o` is 0. If the effective count is N, `aack_o` is high in the (N+1)-th cycle after that edge, for exactly one cycle. A count of 0 acknowledges in the first cycle after the transfer start.
- R3: For a processor transfer (`init_bridge_i`=0), the effective count is at least `addr_ws_i`. When `l2_present_i`=1 it is also at least `l2_dly_i`. When `l2_present_i`=0, `l2_dly_i` has no effect.
- R4: For a processor transfer with `multi_cpu_i`=1, the effective count is at least `snoop_ws_i`. When `multi_cpu_i`=0, `snoop_ws_i` has no effect on processor transfers.
- R5: For a processor transfer with `ratio_1to1_i`=1, the effective count is at least 1. For a processor transfer, the effective count is exactly the maximum of the applicable values.
- R6: For a bridge transfer (`init_bridge_i`=1), the effective count is `snoop_ws_i` plus 1 if `pipe_busy_i`=1. `addr_ws_i`, `l2_dly_i`, `l2_present_i`, `multi_cpu_i` and `ratio_1to1_i` have no effect.
- R7: `retry_o` equals `retry_i` in the `aack_o` cycle and is 0 in every other cycle. `retry_i` in any other cycle has no effect on any output.
- R8: `data_req_o` pulses in the `aack_o` cycle only when `retry_i` is 0 there, and is 0 otherwise.
- R9: `retried_o` takes the `retry_i` value sampled at `aack_o` from the next cycle onward. It holds that value until the next accepted transfer start, which clears it.
- R10: `ts_i` while `busy_o` is 1 (including the `aack_o` cycle) is ignored: it produces no extra acknowledge. `busy_o` is 1 from the cycle after an accepted start through the `aack_o` cycle.
- R11: The fields and options are sampled only on the accepted start edge. Changing them during the countdown does not move `aack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ts_i | input | 1 | Transfer start pulse |
| init_bridge_i | input | 1 | 1 = bridge-initiated, 0 = processor-initiated |
| addr_ws_i | input | FIELD_W | Minimum address-phase wait states (processor) |
| l2_dly_i | input | FIELD_W | L2 hit delay in cycles |
| snoop_ws_i | input | FIELD_W | Snoop response wait states |
| l2_present_i | input | 1 | L2 cache fitted |
| multi_cpu_i | input | 1 | Multiprocessor system |
| ratio_1to1_i | input | 1 | Processor runs at bus clock rate |
| pipe_busy_i | input | 1 | Bus pipeline busy (bridge adds one wait) |
| retry_i | input | 1 | Snoop retry input |
| aack_o | output | 1 | Address acknowledge, one cycle |
| retry_o | output | 1 | Retry sampled in the acknowledge cycle |
| data_req_o | output | 1 | Data tenure request, one cycle |
| retried_o | output | 1 | Last tenure was retried |
| busy_o | output | 1 | Address tenure in progress |

## Verification
The bench builds the block with the default FIELD_W of 3 and the default ratio minimum of 1. Every field can therefore take each of its eight values, and the longest count is eight, reached by a bridge transfer with a full snoop field and a busy pipeline. Random tenures draw the fields and options freely, so the max-of-fields rule, the bridge path and the 1:1 floor each come up many times. Directed cases cover the zero-wait acknowledge, the longest count, stray starts and retries raised away from the acknowledge cycle.

// File: rtl/awc_pkg.sv
package awc_pkg;
  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/awc_calc.sv
module awc_calc #(
  parameter int FIELD_W   = 3,
  parameter int RATIO_MIN = 1,
  localparam int CNT_W    = FIELD_W + 1
) (
  input  logic               init_bridge_i,
  input  logic [FIELD_W-1:0] addr_ws_i,
  input  logic [FIELD_W-1:0] l2_dly_i,
  input  logic [FIELD_W-1:0] snoop_ws_i,
  input  logic               l2_present_i,
  input  logic               multi_cpu_i,
  input  logic               ratio_1to1_i,
  input  logic               pipe_busy_i,
  output logic [CNT_W-1:0]   count_o
);
  import awc_pkg::*;
  localparam int NCAND = 4;

  logic [CNT_W-1:0] cand [NCAND];
  logic [CNT_W-1:0] cpu_cnt;
  logic [CNT_W-1:0] brg_cnt;

  always_comb begin
    cand[0] = CNT_W'(addr_ws_i);
    cand[1] = l2_present_i ? CNT_W'(l2_dly_i) : '0;
    cand[2] = multi_cpu_i  ? CNT_W'(snoop_ws_i) : '0;
    cand[3] = ratio_1to1_i ? CNT_W'(RATIO_MIN) : '0;
  end

  always_comb begin
    cpu_cnt = '0;
    for (int i = 0; i < NCAND; i++)
      cpu_cnt = CNT_W'(umax(int'(cpu_cnt), int'(cand[i])));
  end

  assign brg_cnt = CNT_W'(snoop_ws_i) + CNT_W'(pipe_busy_i);
  assign count_o = init_bridge_i ? brg_cnt : cpu_cnt;
endmodule

// File: rtl/awc_counter.sv
module awc_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             active_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!act_q) begin
      if (start_i) begin
        cnt_q <= load_i;
        act_q <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = act_q;
  assign expire_o = act_q && (cnt_q == '0);
endmodule

// File: rtl/addr_wait_ctrl.sv
module addr_wait_ctrl #(
  parameter int FIELD_W   = 3,
  parameter int RATIO_MIN = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ts_i,
  input  logic               init_bridge_i,
  input  logic [FIELD_W-1:0] addr_ws_i,
  input  logic [FIELD_W-1:0] l2_dly_i,
  input  logic [FIELD_W-1:0] snoop_ws_i,
  input  logic               l2_present_i,
  input  logic               multi_cpu_i,
  input  logic               ratio_1to1_i,
  input  logic               pipe_busy_i,
  input  logic               retry_i,
  output logic               aack_o,
  output logic               retry_o,
  output logic               data_req_o,
  output logic               retried_o,
  output logic               busy_o
);
  localparam int CNT_W = FIELD_W + 1;

  logic [CNT_W-1:0] eff_cnt;
  logic             active, expire, accept;
  logic             retried_q;

  awc_calc #(.FIELD_W(FIELD_W), .RATIO_MIN(RATIO_MIN)) calc_i (
    .init_bridge_i(init_bridge_i), .addr_ws_i(addr_ws_i), .l2_dly_i(l2_dly_i),
    .snoop_ws_i(snoop_ws_i), .l2_present_i(l2_present_i), .multi_cpu_i(multi_cpu_i),
    .ratio_1to1_i(ratio_1to1_i), .pipe_busy_i(pipe_busy_i), .count_o(eff_cnt)
  );

  awc_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .start_i(ts_i), .load_i(eff_cnt),
    .active_o(active), .expire_o(expire)
  );

  assign accept = ts_i && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      retried_q <= 1'b0;
    else if (accept) retried_q <= 1'b0;
    else if (expire) retried_q <= retry_i;
  end

  assign aack_o     = expire;
  assign retry_o    = expire && retry_i;
  assign data_req_o = expire && !retry_i;
  assign retried_o  = retried_q;
  assign busy_o     = active;
endmodule

// File: rtl/awc_checker.sv
module awc_checker (
  input logic clk,
  input logic rst_n,
  input logic ts_i,
  input logic retry_i,
  input logic aack_o,
  input logic retry_o,
  input logic data_req_o,
  input logic retried_o,
  input logic busy_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !aack_o && !data_req_o && !busy_o); // R1
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) aack_o |=> !aack_o); // R2
  AST_ACK_ENDS_TENURE: assert property (@(posedge clk) disable iff (!rst_n) aack_o |=> !busy_o); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) (ts_i && !busy_o) |=> busy_o); // R2
  AST_RETRY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n) retry_o |-> aack_o && retry_i); // R7
  AST_DREQ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) data_req_o |-> aack_o && !retry_i); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!aack_o && !(ts_i && !busy_o)) |=> $stable(retried_o)); // R9
endmodule

bind addr_wait_ctrl awc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .retry_i(retry_i), .aack_o(aack_o),
  .retry_o(retry_o), .data_req_o(data_req_o), .retried_o(retried_o), .busy_o(busy_o)
);

// File: tb/addr_wait_ctrl_tb.sv
module addr_wait_ctrl_tb_top;
  localparam int FW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ts_i = 0, init_bridge_i = 0, l2_present_i = 0, multi_cpu_i = 0;
  logic ratio_1to1_i = 0, pipe_busy_i = 0, retry_i = 0;
  logic [FW-1:0] addr_ws_i = '0, l2_dly_i = '0, snoop_ws_i = '0;
  logic aack_o, retry_o, data_req_o, retried_o, busy_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_wait_ctrl #(.FIELD_W(FW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int exp_n(input bit brg, input int aws, input int l2d, input int snw,
                               input bit l2p, input bit mp, input bit fast, input bit pipe);
    int n;
    if (brg) return snw + (pipe ? 1 : 0);
    n = aws;
    if (l2p && l2d > n) n = l2d;
    if (mp && snw > n) n = snw;
    if (fast && n < 1) n = 1;
    return n;
  endfunction

  task automatic tenure(input bit brg, input int aws, input int l2d, input int snw, input bit l2p,
                        input bit mp, input bit fast, input bit pipe, input bit ret, input int stray);
    int n;
    @(negedge clk);
    init_bridge_i = brg; addr_ws_i = FW'(aws); l2_dly_i = FW'(l2d); snoop_ws_i = FW'(snw);
    l2_present_i = l2p; multi_cpu_i = mp; ratio_1to1_i = fast; pipe_busy_i = pipe;
    ts_i = 1; retry_i = 1'($urandom);
    n = exp_n(brg, aws, l2d, snw, l2p, mp, fast, pipe);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      ts_i = (k == stray);
      // R11: scramble configuration during the countdown
      init_bridge_i = 1'($urandom); addr_ws_i = FW'($urandom); l2_dly_i = FW'($urandom);
      snoop_ws_i = FW'($urandom); l2_present_i = 1'($urandom); multi_cpu_i = 1'($urandom);
      ratio_1to1_i = 1'($urandom); pipe_busy_i = 1'($urandom);
      retry_i = (k == n) ? ret : 1'($urandom);
      #1;
      chk(aack_o == (k == n), (brg ? "R6 aack timing" : "R2 R3 R4 R5 R11 aack timing"), aack_o, k == n);
      chk(busy_o == 1'b1, "R10 busy during tenure", busy_o, 1);
      if (k == 0) chk(retried_o == 1'b0, "R9 flag cleared on start", retried_o, 0);
      if (k < n) begin
        chk(retry_o == 1'b0, "R7 retry outside ack", retry_o, 0);
        chk(data_req_o == 1'b0, "R8 dreq outside ack", data_req_o, 0);
      end else begin
        chk(retry_o == ret, "R7 retry at ack", retry_o, ret);
        chk(data_req_o == !ret, "R8 dreq at ack", data_req_o, !ret);
      end
    end
    @(negedge clk);
    ts_i = 0; retry_i = 1'($urandom); #1;
    chk(busy_o == 1'b0 && aack_o == 1'b0, "R10 no extra tenure", {busy_o, aack_o}, 0);
    chk(retried_o == ret, "R9 flag after ack", retried_o, ret);
    @(negedge clk);
    retry_i = ~retry_i; #1;
    chk(retried_o == ret && aack_o == 1'b0, "R9 R7 flag holds", retried_o, ret);
  endtask

  initial begin
    process::self().srandom(32'h5EED_0105);
    #2; #1;
    chk(aack_o == 0 && retry_o == 0 && data_req_o == 0 && retried_o == 0 && busy_o == 0,
        "R1 reset state", {aack_o, retry_o, data_req_o, retried_o, busy_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // directed corners
    tenure(0, 0, 0, 0, 0, 0, 0, 0, 0, -1);  // R2 zero wait
    tenure(0, 0, 0, 0, 0, 0, 1, 0, 1, -1);  // R5 1:1 floor
    tenure(0, 2, 7, 5, 0, 0, 0, 0, 0, -1);  // R3 R4 options off
    tenure(0, 1, 6, 3, 1, 0, 0, 0, 1, 2);   // R3 l2 raises, stray start R10
    tenure(0, 1, 2, 7, 1, 1, 0, 0, 0, 7);   // R4 snoop raises, stray at ack
    tenure(1, 7, 7, 7, 1, 1, 1, 1, 0, -1);  // R6 longest count
    tenure(1, 5, 5, 0, 1, 1, 1, 0, 1, 0);   // R6 bridge zero
    for (int t = 0; t < 400; t++)
      tenure(1'($urandom), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             int'($urandom % 10) - 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule